// File: doc/BRIEF.md
# Three-Stage Phase-Change Write Sequencer

This block drives the programming of one write unit in a phase-change memory array when the instantaneous supply current is capped. A request carries the word that the cells hold now and the encoded word that should replace it. The sequencer runs three stages in a fixed order. It first compares the two words in a single cycle. It then resets the cells that must change from one to zero. Last, it sets the cells that must change from zero to one. Cells whose stored value already matches are never pulsed. This avoids the needless reset and re-set of unchanged ones.

Reset pulses are short but draw more current, and set pulses are long but draw less. Within each stage the pending cells are grouped into batches. Each batch takes the lowest-indexed pending cells, up to the number whose summed current fits the budget. A batch holds its enables for the stage's pulse length. The next batch then follows with no gap. An empty stage costs no cycles. Completion is flagged by a one-cycle done pulse, after which the sequencer accepts the next request.

Top module: `pcm_write_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and both pulse buses are all zero.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance up to and including the `done` cycle. `req_valid` during that time has no effect on the pulses that are produced.
- R3: For each bit position i, cell i needs a reset when `req_old[i]`=1 and `req_new[i]`=0. It needs a set when `req_old[i]`=0 and `req_new[i]`=1. Bit i of `rst_pulse` and of `set_pulse` drives cell i.
- R4: All reset pulses of a write finish before any set pulse starts. `rst_pulse` and `set_pulse` are never nonzero in the same cycle.
- R5: Every cell that needs a reset sees exactly one contiguous run of RST_CYC cycles on `rst_pulse`. Every cell that needs a set sees exactly one contiguous run of SET_CYC cycles on `set_pulse` (defaults 5 and 43).
- R6: A cell whose old and new values are equal receives no pulse in either stage.
- R7: In every cycle, popcount(`rst_pulse`)×RST_COST + popcount(`set_pulse`)×SET_COST ≤ BUDGET (defaults 2, 1 and 8).
- R8: A batch holds the lowest-indexed pending cells of its stage, up to BUDGET/cost cells, rounded down.
- R9: With n0 reset cells and n1 set cells, let b0 = ceil(n0/(BUDGET/RST_COST)) and b1 = ceil(n1/(BUDGET/SET_COST)). Counting from the accepting edge, `done` is 1 after exactly 2 + b0·RST_CYC + b1·SET_CYC clock edges. An empty stage adds no cycles.
- R10: `done` is high for exactly one cycle. `req_ready` is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_old | input | WIDTH | Word currently stored in the cells |
| req_new | input | WIDTH | Encoded word to be stored |
| rst_pulse | output | WIDTH | Per-cell reset (write-zero) program enable |
| set_pulse | output | WIDTH | Per-cell set (write-one) program enable |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench covers several corner cases. The first is a write whose two words are equal: a sequencer that did not skip empty stages would spend pulse time there, or would pulse unchanged cells. It also uses reset counts that land exactly on and one past the batch size. A batch picker that is off by one would then exceed the current cap or add an extra batch, and the latency check would catch either. A full inversion in both directions exercises the longest batch chains. Requests presented while the sequencer is busy must leave the pulse pattern of the write in progress intact. A design that latched them would pulse the wrong cells.

// File: rtl/pcm_seq_pkg.sv
package pcm_seq_pkg;
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_CMP,
        SEQ_WR0,
        SEQ_WR1,
        SEQ_DONE
    } seq_state_e;
endpackage

// File: rtl/pcm_diff_unit.sv
// Compares the stored word with the target word and splits the differing
// cells into those that must go to zero and those that must go to one.
module pcm_diff_unit #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cur_word,
    input  logic [WIDTH-1:0] tgt_word,
    output logic [WIDTH-1:0] to_zero,
    output logic [WIDTH-1:0] to_one
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign to_zero[i] = cur_word[i] & ~tgt_word[i];
        assign to_one[i]  = ~cur_word[i] & tgt_word[i];
    end
endmodule

// File: rtl/pcm_batch_pick.sv
// Selects up to MAX_SEL lowest-indexed set bits of a pending mask.
module pcm_batch_pick #(
    parameter int WIDTH   = 16,
    parameter int MAX_SEL = 4
) (
    input  logic [WIDTH-1:0] pending,
    output logic [WIDTH-1:0] batch
);
    localparam int CW = $clog2(WIDTH + 1) + 1;
    localparam logic [CW-1:0] LIMIT = CW'(MAX_SEL);

    always_comb begin
        logic [CW-1:0] taken;
        taken = '0;
        batch = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (pending[i] && (taken < LIMIT)) begin
                batch[i] = 1'b1;
                taken    = taken + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcm_write_seq.sv
module pcm_write_seq
    import pcm_seq_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int RST_CYC  = 5,
    parameter int SET_CYC  = 43,
    parameter int BUDGET   = 8,
    parameter int RST_COST = 2,
    parameter int SET_COST = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [WIDTH-1:0] req_old,
    input  logic [WIDTH-1:0] req_new,
    output logic [WIDTH-1:0] rst_pulse,
    output logic [WIDTH-1:0] set_pulse,
    output logic             done
);
    localparam int RST_PER_BATCH = (BUDGET / RST_COST) < 1 ? 1 : (BUDGET / RST_COST);
    localparam int SET_PER_BATCH = (BUDGET / SET_COST) < 1 ? 1 : (BUDGET / SET_COST);
    localparam int MAX_CYC       = (RST_CYC > SET_CYC) ? RST_CYC : SET_CYC;
    localparam int TW            = $clog2(MAX_CYC + 1);
    localparam logic [TW-1:0] RST_LOAD = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] SET_LOAD = TW'(SET_CYC - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [WIDTH-1:0] cur;
        logic [WIDTH-1:0] tgt;
        logic [WIDTH-1:0] pend0;
        logic [WIDTH-1:0] pend1;
        logic [WIDTH-1:0] batch;
        logic [TW-1:0]    tmr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [WIDTH-1:0] diff_zero, diff_one;
    logic [WIDTH-1:0] pick0_in, pick1_in;
    logic [WIDTH-1:0] pick0, pick1;

    pcm_diff_unit #(.WIDTH(WIDTH)) u_diff (
        .cur_word (r_q.cur),
        .tgt_word (r_q.tgt),
        .to_zero  (diff_zero),
        .to_one   (diff_one)
    );

    assign pick0_in = (r_q.st == SEQ_CMP) ? diff_zero : r_q.pend0;
    assign pick1_in = (r_q.st == SEQ_CMP) ? diff_one  : r_q.pend1;

    pcm_batch_pick #(.WIDTH(WIDTH), .MAX_SEL(RST_PER_BATCH)) u_pick_rst (
        .pending (pick0_in),
        .batch   (pick0)
    );

    pcm_batch_pick #(.WIDTH(WIDTH), .MAX_SEL(SET_PER_BATCH)) u_pick_set (
        .pending (pick1_in),
        .batch   (pick1)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SEQ_IDLE: begin
                if (req_valid) begin
                    r_d.cur = req_old;
                    r_d.tgt = req_new;
                    r_d.st  = SEQ_CMP;
                end
            end
            SEQ_CMP: begin
                r_d.pend0 = diff_zero;
                r_d.pend1 = diff_one;
                if (|diff_zero) begin
                    r_d.st    = SEQ_WR0;
                    r_d.batch = pick0;
                    r_d.pend0 = diff_zero & ~pick0;
                    r_d.tmr   = RST_LOAD;
                end else if (|diff_one) begin
                    r_d.st    = SEQ_WR1;
                    r_d.batch = pick1;
                    r_d.pend1 = diff_one & ~pick1;
                    r_d.tmr   = SET_LOAD;
                end else begin
                    r_d.st    = SEQ_DONE;
                    r_d.batch = '0;
                end
            end
            SEQ_WR0: begin
                if (r_q.tmr != '0) begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end else if (|r_q.pend0) begin
                    r_d.batch = pick0;
                    r_d.pend0 = r_q.pend0 & ~pick0;
                    r_d.tmr   = RST_LOAD;
                end else if (|r_q.pend1) begin
                    r_d.st    = SEQ_WR1;
                    r_d.batch = pick1;
                    r_d.pend1 = r_q.pend1 & ~pick1;
                    r_d.tmr   = SET_LOAD;
                end else begin
                    r_d.st    = SEQ_DONE;
                    r_d.batch = '0;
                end
            end
            SEQ_WR1: begin
                if (r_q.tmr != '0) begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end else if (|r_q.pend1) begin
                    r_d.batch = pick1;
                    r_d.pend1 = r_q.pend1 & ~pick1;
                    r_d.tmr   = SET_LOAD;
                end else begin
                    r_d.st    = SEQ_DONE;
                    r_d.batch = '0;
                end
            end
            SEQ_DONE: begin
                r_d.st = SEQ_IDLE;
            end
            default: begin
                r_d.st = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SEQ_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == SEQ_IDLE);
    assign done      = (r_q.st == SEQ_DONE);
    assign rst_pulse = (r_q.st == SEQ_WR0) ? r_q.batch : '0;
    assign set_pulse = (r_q.st == SEQ_WR1) ? r_q.batch : '0;
endmodule

// File: rtl/pcm_write_seq_chk.sv
module pcm_write_seq_chk #(
    parameter int WIDTH    = 16,
    parameter int BUDGET   = 8,
    parameter int RST_COST = 2,
    parameter int SET_COST = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [WIDTH-1:0] rst_pulse,
    input logic [WIDTH-1:0] set_pulse,
    input logic             done
);
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_not_ready_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !((|rst_pulse) && (|set_pulse)));

    p_no_reset_after_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_pulse) |=> !(|rst_pulse));

    p_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rst_pulse) * RST_COST + $countones(set_pulse) * SET_COST) <= BUDGET);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rst_pulse == '0 && set_pulse == '0 && !done));
endmodule

bind pcm_write_seq pcm_write_seq_chk #(
    .WIDTH(WIDTH), .BUDGET(BUDGET), .RST_COST(RST_COST), .SET_COST(SET_COST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rst_pulse (rst_pulse),
    .set_pulse (set_pulse),
    .done      (done)
);

// File: tb/tb_pcm_write_seq.sv
module tb_pcm_write_seq;
    localparam int W   = 16;
    localparam int RC  = 5;
    localparam int SC  = 43;
    localparam int BG  = 8;
    localparam int RCO = 2;
    localparam int SCO = 1;
    localparam int K0  = BG / RCO;
    localparam int K1  = BG / SCO;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [W-1:0] req_old = '0;
    logic [W-1:0] req_new = '0;
    logic [W-1:0] rst_pulse, set_pulse;
    logic         done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int seed_dummy;

    pcm_write_seq #(
        .WIDTH(W), .RST_CYC(RC), .SET_CYC(SC),
        .BUDGET(BG), .RST_COST(RCO), .SET_COST(SCO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_old(req_old), .req_new(req_new),
        .rst_pulse(rst_pulse), .set_pulse(set_pulse), .done(done)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int popc(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [W-1:0] first_k(input logic [W-1:0] m, input int k);
        logic [W-1:0] s = '0;
        int n = 0;
        for (int i = 0; i < W; i++) begin
            if (m[i] && n < k) begin
                s[i] = 1'b1;
                n++;
            end
        end
        return s;
    endfunction

    function automatic int nbatch(input int n, input int k);
        return (n + k - 1) / k;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_txn(input logic [W-1:0] o, input logic [W-1:0] n, input bit poke);
        logic [W-1:0] m0, m1, prev_r, prev_s, first_r, first_s;
        int cnt_r[W];
        int cnt_s[W];
        int rises_r[W];
        int rises_s[W];
        int edges, exp_lat;
        bit seen_set, order_bad, budget_bad, ready_bad, got_fr, got_fs;
        m0 = o & ~n;
        m1 = ~o & n;
        exp_lat = 2 + nbatch(popc(m0), K0) * RC + nbatch(popc(m1), K1) * SC;
        for (int i = 0; i < W; i++) begin
            cnt_r[i] = 0; cnt_s[i] = 0; rises_r[i] = 0; rises_s[i] = 0;
        end
        prev_r = '0; prev_s = '0; first_r = '0; first_s = '0;
        seen_set = 0; order_bad = 0; budget_bad = 0; ready_bad = 0;
        got_fr = 0; got_fs = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_old   = o;
        req_new   = n;
        @(posedge clk);
        @(negedge clk);
        edges = 1;
        req_valid = 1'b0;
        while (!done && edges < 2000) begin
            if (req_ready) ready_bad = 1;
            if (popc(rst_pulse) * RCO + popc(set_pulse) * SCO > BG) budget_bad = 1;
            if (|set_pulse) seen_set = 1;
            if ((|rst_pulse) && seen_set) order_bad = 1;
            if ((|rst_pulse) && !got_fr) begin first_r = rst_pulse; got_fr = 1; end
            if ((|set_pulse) && !got_fs) begin first_s = set_pulse; got_fs = 1; end
            for (int i = 0; i < W; i++) begin
                cnt_r[i] += int'(rst_pulse[i]);
                cnt_s[i] += int'(set_pulse[i]);
                rises_r[i] += int'(rst_pulse[i] & ~prev_r[i]);
                rises_s[i] += int'(set_pulse[i] & ~prev_s[i]);
            end
            prev_r = rst_pulse;
            prev_s = set_pulse;
            if (poke) begin
                req_valid = 1'b1;
                req_old   = W'($urandom);
                req_new   = W'($urandom);
            end
            @(posedge clk);
            @(negedge clk);
            edges++;
        end
        req_valid = 1'b0;
        check(edges == exp_lat, "R9", "latency to done", edges, exp_lat);
        check(!ready_bad && !req_ready, "R2", "ready low while busy", req_ready, 0);
        check(!order_bad, "R4", "reset after set", order_bad, 0);
        check(!budget_bad, "R7", "current budget", budget_bad, 0);
        check(first_r == first_k(m0, K0), "R8", "first reset batch", first_r, first_k(m0, K0));
        check(first_s == first_k(m1, K1), "R8", "first set batch", first_s, first_k(m1, K1));
        for (int i = 0; i < W; i++) begin
            if (m0[i]) begin
                check(cnt_r[i] == RC && rises_r[i] == 1, "R5", "reset run length", cnt_r[i], RC);
                check(cnt_s[i] == 0, "R3", "set pulse on reset cell", cnt_s[i], 0);
            end else if (m1[i]) begin
                check(cnt_s[i] == SC && rises_s[i] == 1, "R5", "set run length", cnt_s[i], SC);
                check(cnt_r[i] == 0, "R3", "reset pulse on set cell", cnt_r[i], 0);
            end else begin
                check(cnt_r[i] + cnt_s[i] == 0, "R6", "pulse on unchanged cell",
                      cnt_r[i] + cnt_s[i], 0);
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(!done && req_ready, "R10", "done single cycle then ready", {done, req_ready}, 1);
    endtask

    initial begin
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(done == 1'b0 && rst_pulse == '0 && set_pulse == '0, "R1", "quiet after reset",
              {done, rst_pulse, set_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after release", req_ready, 1);
        // directed corners
        run_txn(16'hA5A5, 16'hA5A5, 0);        // R9: both stages empty
        run_txn(16'h000F, 16'h0000, 0);        // R8: exactly one reset batch
        run_txn(16'h001F, 16'h0000, 0);        // R8: one past batch size
        run_txn(16'hFFFF, 16'h0000, 0);        // full reset chain
        run_txn(16'h0000, 16'hFFFF, 0);        // full set chain
        run_txn(16'h00FF, 16'hFF00, 1);        // R2: pokes while busy
        run_txn(16'h0000, 16'h0100, 0);        // single set cell
        for (int t = 0; t < 150; t++) begin
            run_txn(W'($urandom), W'($urandom), ($urandom % 3) == 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule